// File: doc/BRIEF.md
# Descriptor-Walking Transmit Frame Buffer

This block holds outgoing frame data written by a host and hands it to a byte-wide transmitter. The host pushes 32-bit words through a data port into a circular 16 KiB byte buffer. It fills a ring of descriptors, each with a ready flag, a byte length and a buffer pointer. It then announces each queued frame with a one-cycle increment pulse, which raises a queued-frame counter.

A transmit command starts a walk over the descriptor ring. The walk begins at the current ring index and visits at most as many descriptors as were queued when the command arrived. Each ready descriptor of legal length is streamed out one byte per accepted handshake. The read position comes from the descriptor pointer less a fixed base, and it wraps to offset zero past the buffer end. A descriptor is then handed back: its ready flag drops, the index moves on and the queued count falls by one. When the walk finishes, two sticky interrupt causes report whether anything was handed back and whether the walk stopped short of the queued count.

Top module: `tx_frame_buffer`

## Requirements
- R1: Every `wr_en` cycle stores `wr_data` at word `wr_ptr/4` and advances `wr_ptr` by 4 modulo 16384. The byte at buffer address 4k+j is bits [8j+7:8j] of the stored word.
- R2: While `swap_en` is high during a write, the stored word is the input with its four bytes reversed, so input bits [7:0] land at lane 3.
- R3: A `frame_inc` pulse raises `frame_cnt` by one. Each handed-back descriptor lowers it by one. Both events in the same cycle leave it unchanged.
- R4: A `tx_go` pulse latches `frame_cnt` as the walk limit and starts at `desc_idx`. The walk ends once the limit is reached, or earlier at a descriptor whose ready flag is clear, which is left untouched.
- R5: A sent frame starts at offset (pointer − 0x1000) mod 16384. Its bytes leave in ascending address order, continue from offset 0 after 16383, and `tx_last` marks the final byte.
- R6: A ready descriptor whose length is 0 or above 1514 sends no byte but is still handed back.
- R7: Handing back a descriptor clears its ready bit in `desc_ready` and moves `desc_idx` to the next entry. The index goes from DESC_COUNT−1 to 0.
- R8: At the end of a walk, `irq_dnv` is set if the number handed back differs from the latched limit or the limit was 0. `irq_txend` is set if at least one descriptor was handed back. Both causes stay set until `irq_clr` bit 0 (txend) or bit 1 (dnv) is pulsed.
- R9: A `fifo_clr` pulse sets `frame_cnt`, `desc_idx` and `wr_ptr` to 0, returns the read position to 0 and aborts any walk. It leaves descriptors and buffer contents unchanged.
- R10: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_byte` and `tx_last` hold and the walk does not advance.
- R11: After reset, `tx_valid`, `busy` and both interrupt causes are low, and `frame_cnt`, `desc_idx` and `wr_ptr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host data-port write strobe |
| wr_data | input | 32 | Host data word |
| swap_en | input | 1 | Reverse the word's bytes on write |
| fifo_clr | input | 1 | Transmit-side clear pulse |
| frame_inc | input | 1 | Queued-frame increment pulse |
| desc_we | input | 1 | Descriptor write strobe |
| desc_sel | input | 6 | Descriptor entry to write |
| desc_rdy | input | 1 | Ready flag to write |
| desc_len | input | 16 | Frame length in bytes |
| desc_ptr | input | 16 | Frame buffer pointer (base 0x1000) |
| tx_go | input | 1 | Transmit command pulse |
| irq_clr | input | 2 | Cause clear: bit 0 txend, bit 1 dnv |
| tx_ready | input | 1 | Byte sink ready |
| tx_valid | output | 1 | Byte valid |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of a frame |
| busy | output | 1 | Walk in progress |
| frame_cnt | output | 8 | Queued-frame count |
| desc_idx | output | 6 | Current descriptor index |
| desc_ready | output | 64 | Ready flags of all descriptors |
| wr_ptr | output | 14 | Data-port write byte address |
| irq_txend | output | 1 | Transmit-end cause |
| irq_dnv | output | 1 | Descriptor-not-valid cause |

## Verification
A stale read position or an offset computed from the wrong base shows up at the first outgoing byte of a frame, as a byte from the wrong buffer address. A missed wrap shows up on the first byte past offset 16383. A lost or doubled hand-back shows up in the cycle after the walk ends, as a wrong `desc_idx`, a wrong `frame_cnt`, or a ready bit left set. The next command then starts on the wrong descriptor. A wrong walk limit or a bad completion count shows up in the interrupt causes as soon as `busy` falls.

// File: rtl/tx_frame_buffer_pkg.sv
package tx_frame_buffer_pkg;

  typedef enum logic [2:0] {
    WALK_IDLE,
    WALK_LOOK,
    WALK_SEND,
    WALK_FREE,
    WALK_DONE
  } walk_state_t;

  function automatic logic [31:0] reverse_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [7:0] pick_lane(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

endpackage

// File: rtl/tx_buf_store.sv
module tx_buf_store
  import tx_frame_buffer_pkg::*;
#(
  parameter int BUF_BYTES = 16384,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int WORDS = BUF_BYTES / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          swap_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  output logic [AW-1:0] wr_ptr
);

  logic [31:0] mem [WORDS];
  logic [AW-1:0] wp;

  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      mem[wp[AW-1:2]] <= swap_en ? reverse_bytes(wr_data) : wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
    end else if (clr) begin
      wp <= '0;
    end else if (wr_en) begin
      wp <= wp + AW'(4);
    end
  end

  assign rd_byte = pick_lane(mem[rd_addr[AW-1:2]], rd_addr[1:0]);
  assign wr_ptr  = wp;

endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring #(
  parameter int DESC_COUNT = 64,
  parameter int LW = 16,
  localparam int IW = $clog2(DESC_COUNT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [IW-1:0]         host_sel,
  input  logic                  host_rdy,
  input  logic [LW-1:0]         host_len,
  input  logic [LW-1:0]         host_ptr,
  input  logic                  free_en,
  input  logic [IW-1:0]         look_idx,
  output logic                  look_rdy,
  output logic [LW-1:0]         look_len,
  output logic [LW-1:0]         look_ptr,
  output logic [DESC_COUNT-1:0] rdy_vec
);

  logic [LW-1:0] len_q [DESC_COUNT];
  logic [LW-1:0] ptr_q [DESC_COUNT];
  logic [DESC_COUNT-1:0] rdy_q;

  for (genvar g = 0; g < DESC_COUNT; g++) begin : g_entry
    logic hit_host;
    logic hit_free;
    assign hit_host = host_we && (host_sel == IW'(g));
    assign hit_free = free_en && (look_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q[g] <= 1'b0;
      end else if (hit_host) begin
        rdy_q[g] <= host_rdy;
      end else if (hit_free) begin
        rdy_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_host) begin
        len_q[g] <= host_len;
        ptr_q[g] <= host_ptr;
      end
    end
  end

  assign look_rdy = rdy_q[look_idx];
  assign look_len = len_q[look_idx];
  assign look_ptr = ptr_q[look_idx];
  assign rdy_vec  = rdy_q;

endmodule

// File: rtl/tx_walker.sv
module tx_walker
  import tx_frame_buffer_pkg::*;
#(
  parameter int BUF_BYTES = 16384,
  parameter int DESC_COUNT = 64,
  parameter int CNT_W = 8,
  parameter int LW = 16,
  parameter int PTR_BASE = 'h1000,
  parameter int MAX_FRAME = 1514,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int IW = $clog2(DESC_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             go,
  input  logic             frame_inc,
  input  logic [1:0]       irq_clr,
  input  logic             cur_rdy,
  input  logic [LW-1:0]    cur_len,
  input  logic [LW-1:0]    cur_ptr,
  input  logic             tx_ready,
  output logic [IW-1:0]    idx,
  output logic [AW-1:0]    rd_addr,
  output logic             free_ev,
  output logic             fin_ev,
  output logic [CNT_W-1:0] fcnt,
  output logic             busy,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             irq_txend,
  output logic             irq_dnv
);

  function automatic logic [AW-1:0] buf_offset(input logic [LW-1:0] p);
    return AW'(p - LW'(PTR_BASE));
  endfunction

  function automatic logic len_sendable(input logic [LW-1:0] n);
    return (n != '0) && (n <= LW'(MAX_FRAME));
  endfunction

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
    return (i == IW'(DESC_COUNT - 1)) ? '0 : i + 1'b1;
  endfunction

  walk_state_t st;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] done_q;
  logic [LW-1:0]    left_q;
  logic             short_walk;

  assign free_ev    = (st == WALK_FREE);
  assign fin_ev     = (st == WALK_DONE);
  assign busy       = (st != WALK_IDLE);
  assign tx_valid   = (st == WALK_SEND);
  assign tx_last    = tx_valid && (left_q == LW'(1));
  assign short_walk = (done_q != limit_q) || (limit_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= WALK_IDLE;
      idx     <= '0;
      rd_addr <= '0;
      limit_q <= '0;
      done_q  <= '0;
      left_q  <= '0;
    end else if (clr) begin
      st      <= WALK_IDLE;
      idx     <= '0;
      rd_addr <= '0;
    end else begin
      unique case (st)
        WALK_IDLE: begin
          if (go) begin
            limit_q <= fcnt;
            done_q  <= '0;
            st      <= WALK_LOOK;
          end
        end
        WALK_LOOK: begin
          if (done_q == limit_q || !cur_rdy) begin
            st <= WALK_DONE;
          end else if (!len_sendable(cur_len)) begin
            st <= WALK_FREE;
          end else begin
            rd_addr <= buf_offset(cur_ptr);
            left_q  <= cur_len;
            st      <= WALK_SEND;
          end
        end
        WALK_SEND: begin
          if (tx_ready) begin
            rd_addr <= rd_addr + 1'b1;
            left_q  <= left_q - 1'b1;
            if (left_q == LW'(1)) st <= WALK_FREE;
          end
        end
        WALK_FREE: begin
          idx    <= next_idx(idx);
          done_q <= done_q + 1'b1;
          st     <= WALK_LOOK;
        end
        WALK_DONE: st <= WALK_IDLE;
        default:   st <= WALK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
    end else if (clr) begin
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + CNT_W'(frame_inc) - CNT_W'(free_ev);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_txend <= 1'b0;
      irq_dnv   <= 1'b0;
    end else begin
      if (fin_ev && done_q != '0) irq_txend <= 1'b1;
      else if (irq_clr[0])        irq_txend <= 1'b0;
      if (fin_ev && short_walk)   irq_dnv <= 1'b1;
      else if (irq_clr[1])        irq_dnv <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_frame_buffer.sv
module tx_frame_buffer
  import tx_frame_buffer_pkg::*;
#(
  parameter int BUF_BYTES = 16384,
  parameter int DESC_COUNT = 64,
  parameter int CNT_W = 8,
  parameter int LW = 16,
  parameter int PTR_BASE = 'h1000,
  parameter int MAX_FRAME = 1514,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int IW = $clog2(DESC_COUNT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  input  logic                  swap_en,
  input  logic                  fifo_clr,
  input  logic                  frame_inc,
  input  logic                  desc_we,
  input  logic [IW-1:0]         desc_sel,
  input  logic                  desc_rdy,
  input  logic [LW-1:0]         desc_len,
  input  logic [LW-1:0]         desc_ptr,
  input  logic                  tx_go,
  input  logic [1:0]            irq_clr,
  input  logic                  tx_ready,
  output logic                  tx_valid,
  output logic [7:0]            tx_byte,
  output logic                  tx_last,
  output logic                  busy,
  output logic [CNT_W-1:0]      frame_cnt,
  output logic [IW-1:0]         desc_idx,
  output logic [DESC_COUNT-1:0] desc_ready,
  output logic [AW-1:0]         wr_ptr,
  output logic                  irq_txend,
  output logic                  irq_dnv
);

  logic [AW-1:0] rd_addr;
  logic          cur_rdy;
  logic [LW-1:0] cur_len;
  logic [LW-1:0] cur_ptr;
  logic          free_ev;
  logic          fin_ev;

  tx_buf_store #(.BUF_BYTES(BUF_BYTES)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .swap_en (swap_en),
    .rd_addr (rd_addr),
    .rd_byte (tx_byte),
    .wr_ptr  (wr_ptr)
  );

  tx_desc_ring #(.DESC_COUNT(DESC_COUNT), .LW(LW)) ring_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_we  (desc_we),
    .host_sel (desc_sel),
    .host_rdy (desc_rdy),
    .host_len (desc_len),
    .host_ptr (desc_ptr),
    .free_en  (free_ev),
    .look_idx (desc_idx),
    .look_rdy (cur_rdy),
    .look_len (cur_len),
    .look_ptr (cur_ptr),
    .rdy_vec  (desc_ready)
  );

  tx_walker #(
    .BUF_BYTES(BUF_BYTES), .DESC_COUNT(DESC_COUNT), .CNT_W(CNT_W),
    .LW(LW), .PTR_BASE(PTR_BASE), .MAX_FRAME(MAX_FRAME)
  ) walk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .go        (tx_go),
    .frame_inc (frame_inc),
    .irq_clr   (irq_clr),
    .cur_rdy   (cur_rdy),
    .cur_len   (cur_len),
    .cur_ptr   (cur_ptr),
    .tx_ready  (tx_ready),
    .idx       (desc_idx),
    .rd_addr   (rd_addr),
    .free_ev   (free_ev),
    .fin_ev    (fin_ev),
    .fcnt      (frame_cnt),
    .busy      (busy),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .irq_txend (irq_txend),
    .irq_dnv   (irq_dnv)
  );

endmodule

// File: rtl/tx_frame_buffer_chk.sv
module tx_frame_buffer_chk #(
  parameter int BUF_BYTES = 16384,
  parameter int DESC_COUNT = 64,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int IW = $clog2(DESC_COUNT)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  fifo_clr,
  input logic                  frame_inc,
  input logic                  desc_we,
  input logic                  tx_ready,
  input logic                  tx_valid,
  input logic [7:0]            tx_byte,
  input logic                  tx_last,
  input logic                  busy,
  input logic [CNT_W-1:0]      frame_cnt,
  input logic [IW-1:0]         desc_idx,
  input logic [DESC_COUNT-1:0] desc_ready,
  input logic [AW-1:0]         wr_ptr,
  input logic                  free_ev,
  input logic                  fin_ev
);

  p_wptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !fifo_clr |=> wr_ptr == AW'($past(wr_ptr) + AW'(4)));

  p_cnt_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_inc && !free_ev && !fifo_clr |=> frame_cnt == CNT_W'($past(frame_cnt) + 1'b1));

  p_cnt_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    free_ev && !frame_inc && !fifo_clr |=> frame_cnt == CNT_W'($past(frame_cnt) - 1'b1));

  p_free_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    free_ev && !desc_we && !fifo_clr |=> !desc_ready[$past(desc_idx)]);

  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    free_ev && !fifo_clr |=> desc_idx == (($past(desc_idx) == IW'(DESC_COUNT - 1)) ? '0 : IW'($past(desc_idx) + 1'b1)));

  p_fin_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev |=> !busy);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> frame_cnt == '0 && desc_idx == '0 && wr_ptr == '0 && !busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !fifo_clr |=> tx_valid && $stable(tx_byte) && $stable(tx_last));

  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

endmodule

bind tx_frame_buffer tx_frame_buffer_chk #(
  .BUF_BYTES(BUF_BYTES), .DESC_COUNT(DESC_COUNT), .CNT_W(CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .fifo_clr   (fifo_clr),
  .frame_inc  (frame_inc),
  .desc_we    (desc_we),
  .tx_ready   (tx_ready),
  .tx_valid   (tx_valid),
  .tx_byte    (tx_byte),
  .tx_last    (tx_last),
  .busy       (busy),
  .frame_cnt  (frame_cnt),
  .desc_idx   (desc_idx),
  .desc_ready (desc_ready),
  .wr_ptr     (wr_ptr),
  .free_ev    (free_ev),
  .fin_ev     (fin_ev)
);

// File: tb/tx_frame_buffer_tb_top.sv
`timescale 1ns/1ps
module tx_frame_buffer_tb_top;

  localparam int NDESC = 64;
  localparam int BYTES = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        swap_en = 1'b0;
  logic        fifo_clr = 1'b0;
  logic        frame_inc = 1'b0;
  logic        desc_we = 1'b0;
  logic [5:0]  desc_sel = '0;
  logic        desc_rdy = 1'b0;
  logic [15:0] desc_len = '0;
  logic [15:0] desc_ptr = '0;
  logic        tx_go = 1'b0;
  logic [1:0]  irq_clr = '0;
  logic        tx_ready = 1'b1;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_last;
  logic        busy;
  logic [7:0]  frame_cnt;
  logic [5:0]  desc_idx;
  logic [63:0] desc_ready;
  logic [13:0] wr_ptr;
  logic        irq_txend;
  logic        irq_dnv;

  always #4 clk = ~clk;

  tx_frame_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .swap_en(swap_en),
    .fifo_clr(fifo_clr), .frame_inc(frame_inc), .desc_we(desc_we), .desc_sel(desc_sel),
    .desc_rdy(desc_rdy), .desc_len(desc_len), .desc_ptr(desc_ptr), .tx_go(tx_go),
    .irq_clr(irq_clr), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_last(tx_last), .busy(busy), .frame_cnt(frame_cnt), .desc_idx(desc_idx),
    .desc_ready(desc_ready), .wr_ptr(wr_ptr), .irq_txend(irq_txend), .irq_dnv(irq_dnv)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model [int];
  int model_wp = 0;
  logic [8:0] exp_q [$];
  bit stall = 1'b0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(input int a);
    logic [31:0] w;
    w = model[(a & (BYTES - 1)) >> 2];
    return 8'(w >> (8 * (a & 3)));
  endfunction

  // Monitor: pops the expected byte stream as the handshake completes
  always @(negedge clk) begin
    cyc++;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected byte", {tx_last, tx_byte}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({tx_last, tx_byte} == e, "R5 byte/last", {tx_last, tx_byte}, e);
      end
    end
  end

  task automatic write_word(input logic [31:0] w, input bit sw);
    wr_en = 1'b1; wr_data = w; swap_en = sw;
    model[model_wp >> 2] = sw ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    model_wp = (model_wp + 4) % BYTES;
    @(negedge clk);
    wr_en = 1'b0; swap_en = 1'b0;
  endtask

  task automatic set_desc(input int i, input bit r, input int len, input int ptr);
    desc_we = 1'b1; desc_sel = 6'(i); desc_rdy = r; desc_len = 16'(len); desc_ptr = 16'(ptr);
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic bump(input int n);
    for (int k = 0; k < n; k++) begin
      frame_inc = 1'b1;
      @(negedge clk);
      frame_inc = 1'b0;
    end
  endtask

  task automatic expect_frame(input int ptr, input int len);
    int off;
    off = (ptr - 'h1000) & (BYTES - 1);
    for (int k = 0; k < len; k++)
      exp_q.push_back({k == len - 1, model_byte(off + k)});
  endtask

  task automatic run_walk();
    int guard;
    guard = 0;
    tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
    forever begin
      @(posedge clk);
      #1 tx_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      @(negedge clk);
      guard++;
      if (!busy || guard > 20000) break;
    end
    tx_ready = 1'b1;
    check(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic clear_irqs();
    irq_clr = 2'b11;
    @(negedge clk);
    irq_clr = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!tx_valid && !busy, "R11 idle", {tx_valid, busy}, 0);
    check(frame_cnt == 0 && desc_idx == 0 && wr_ptr == 0, "R11 counters",
          {frame_cnt, desc_idx, wr_ptr}, 0);
    check(!irq_txend && !irq_dnv, "R11 irqs", {irq_txend, irq_dnv}, 0);

    // R1: pointer step and full-buffer wrap
    for (int i = 0; i < 4; i++) write_word(32'(i) * 32'h9E3779B1 ^ 32'h5A5A0000, 1'b0);
    check(wr_ptr == 16, "R1 pointer step", wr_ptr, 16);
    for (int i = 4; i < BYTES / 4; i++) write_word(32'(i) * 32'h9E3779B1 ^ 32'h5A5A0000, 1'b0);
    check(wr_ptr == 0, "R1 pointer wrap", wr_ptr, 0);

    // R3/R4/R5/R7/R8: two plain frames
    set_desc(0, 1, 5, 'h1000);
    set_desc(1, 1, 8, 'h1010);
    bump(2);
    check(frame_cnt == 2, "R3 increment", frame_cnt, 2);
    expect_frame('h1000, 5);
    expect_frame('h1010, 8);
    run_walk();
    check(frame_cnt == 0 && desc_idx == 2, "R7 index/count after two", {frame_cnt, desc_idx}, 2);
    check(desc_ready[1:0] == 2'b00, "R7 ready released", desc_ready[1:0], 0);
    check(irq_txend && !irq_dnv, "R8 txend only", {irq_txend, irq_dnv}, 2'b10);
    clear_irqs();
    check(!irq_txend && !irq_dnv, "R8 irq clear", {irq_txend, irq_dnv}, 0);

    // R2 byte swap, with R10 backpressure
    write_word(32'h11223344, 1'b1);
    set_desc(2, 1, 4, 'h1000);
    bump(1);
    exp_q.push_back({1'b0, 8'h11});
    exp_q.push_back({1'b0, 8'h22});
    exp_q.push_back({1'b0, 8'h33});
    exp_q.push_back({1'b1, 8'h44});
    stall = 1'b1;
    run_walk();
    stall = 1'b0;
    check(desc_idx == 3, "R2 index after swapped frame", desc_idx, 3);

    // R5 wrap past the buffer end (offset 0x3FFC)
    set_desc(3, 1, 9, 'h0FFC);
    bump(1);
    expect_frame('h0FFC, 9);
    stall = 1'b1;
    run_walk();
    stall = 1'b0;
    check(desc_idx == 4, "R5 index after wrapped frame", desc_idx, 4);
    clear_irqs();

    // R6 oversize descriptor is skipped but released
    set_desc(4, 1, 1515, 'h1000);
    set_desc(5, 1, 3, 'h1020);
    bump(2);
    expect_frame('h1020, 3);
    run_walk();
    check(desc_idx == 6 && frame_cnt == 0, "R6 skip still released", {frame_cnt, desc_idx}, 6);
    check(desc_ready[5:4] == 2'b00, "R6 ready cleared", desc_ready[5:4], 0);
    check(irq_txend && !irq_dnv, "R6 irq", {irq_txend, irq_dnv}, 2'b10);
    clear_irqs();

    // R4/R8 early stop at a descriptor that is not ready
    set_desc(6, 1, 4, 'h1040);
    set_desc(7, 0, 4, 'h1050);
    bump(2);
    expect_frame('h1040, 4);
    run_walk();
    check(desc_idx == 7 && frame_cnt == 1, "R4 early stop", {frame_cnt, desc_idx}, {8'd1, 6'd7});
    check(irq_txend && irq_dnv, "R8 short walk", {irq_txend, irq_dnv}, 2'b11);
    clear_irqs();

    // R9 clear
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    model_wp = 0;
    check(frame_cnt == 0 && desc_idx == 0 && wr_ptr == 0, "R9 clear",
          {frame_cnt, desc_idx, wr_ptr}, 0);

    // R8 command with zero count
    run_walk();
    check(!irq_txend && irq_dnv && desc_idx == 0, "R8 zero count",
          {irq_txend, irq_dnv, desc_idx}, 8'h40);
    clear_irqs();

    // R7 index wrap; R3/R4 increment during a walk is not in the latched limit
    for (int i = 0; i < NDESC - 1; i++) set_desc(i, 1, 2000, 'h1000);
    set_desc(NDESC - 1, 1, 3, 'h1100);
    bump(NDESC);
    expect_frame('h1100, 3);
    fork
      run_walk();
      begin
        repeat (20) @(negedge clk);
        frame_inc = 1'b1;
        @(negedge clk);
        frame_inc = 1'b0;
      end
    join
    check(desc_idx == 0, "R7 index wraps to 0", desc_idx, 0);
    check(frame_cnt == 1, "R3 mid-walk increment kept", frame_cnt, 1);
    check(irq_txend && !irq_dnv, "R4 latched limit met", {irq_txend, irq_dnv}, 2'b10);
    clear_irqs();
    set_desc(0, 1, 2, 'h1200);
    expect_frame('h1200, 2);
    run_walk();
    check(desc_idx == 1 && frame_cnt == 0, "R7 walk after wrap", {frame_cnt, desc_idx}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule